// File: doc/BRIEF.md
# Ping-Pong Buffered DMA Channel

This block is a single DMA channel that moves data between one peripheral and memory. It owns two descriptor sets, A and B. Each set has a current-address register and an end word. The engine drains one set while software refills the other, so a stream of buffers can run with no idle gap between them. Software programs the channel through a small register port. A peripheral asks for each transfer with a request line and gets an acknowledge pulse back. Every transfer is one access on a simple memory request port. An interrupt line tells software when a set has gone empty.

The end word holds the address of the final transfer of a buffer in its low bits. Its top two bits carry termination flags: a last-transfer flag and a stop-after-this-buffer flag. The status register reports three things: which set is in use or will be loaded next, whether the channel has run dry, and whether a set is waiting to be refilled. Software picks the set to reload from the dry flag and the set pointer alone.

Top module: `pingpong_dma_chan`

## Requirements
- R1: Register offsets on `reg_addr` are: 0 current-A, 1 end-A, 2 current-B, 3 end-B, 4 control, 5 status. `reg_rdata` returns the addressed register one cycle after the address is presented. The current and end registers read back exactly as written. Control keeps bits [1:0] (size), 5 (enable) and 6 (direction); every other control bit, including the clear bit 7, reads 0.
- R2: Status bit 0 is the set pointer SEL (0 = A, 1 = B), bit 1 is PEND and bit 2 is DRY. After reset, or after any control write with bit 7 set, both sets are invalid, SEL = 0 and the status reads 6.
- R3: A transfer starts only while enable is 1, the set selected by SEL is valid, the channel is not stopped and `per_req` is high. Each transfer is one memory access (`mem_req` held with a stable address until `mem_ack`) followed by a one-cycle `per_ack` pulse.
- R4: With direction = 1 the engine writes `per_rdata` to memory (`mem_we` = 1). With direction = 0 it reads memory (`mem_we` = 0) and presents the returned data on `per_wdata` during `per_ack`.
- R5: After each transfer that does not finish the buffer, the current address advances by the step that size code control[1:0] gives: code 1 = 1 byte, 2 = 2 bytes, 0 or 3 = 4 bytes.
- R6: The address advance wraps inside an aligned 2^PAGE_W-byte page. The bits at and above PAGE_W never change.
- R7: A buffer is finished after the transfer whose address matches the end word in its low ADDR_W-2 bits. It is also finished after its first transfer if the end word has bit ADDR_W-1 (last-transfer flag) set. A finished set becomes invalid.
- R8: On finishing a buffer without the stop flag, SEL flips. If the other set is valid, transfers continue from it at once.
- R9: DRY = 1 whenever the set selected by SEL is invalid or the channel is stopped, and no transfer starts then. Software refills set A when exactly one of DRY and SEL is 1, and set B otherwise.
- R10: PEND = 1 while either set is invalid or the channel is stopped. It reads 0 once both sets hold unfinished buffers.
- R11: If a finishing buffer has bit ADDR_W-2 (stop flag) of its end word set, the channel stops. DRY and PEND stay 1 and no transfer starts, even after refills, until a clear.
- R12: `irq` equals PEND AND enable, registered, so it follows either of them one cycle later.
- R13: Writing an end register marks that set valid. Writing a current register does not change validity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Registered read data |
| per_req | input | 1 | Peripheral requests a transfer |
| per_ack | output | 1 | One-cycle transfer acknowledge |
| per_rdata | input | DATA_W | Data from peripheral (to memory) |
| per_wdata | output | DATA_W | Data to peripheral (from memory) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ack | input | 1 | Memory access complete |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with ADDR_W = 16, DATA_W = 16 and PAGE_W = 6. The 64-byte page lets a buffer wrap its page in three transfers, and the 16-bit end word puts both termination flags at bits 15 and 14, where the directed tests can set them easily. Under these values the short scenarios reach ping-pong hand-over, running dry with the refill rule, stop-flag latching, the single-transfer flag, both directions and all three step sizes.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;
  localparam logic [2:0] OFF_CURA = 3'd0;
  localparam logic [2:0] OFF_ENDA = 3'd1;
  localparam logic [2:0] OFF_CTRL = 3'd4;
  localparam logic [2:0] OFF_STAT = 3'd5;

  // control bit positions; size code lives in [1:0]
  localparam int CB_EN  = 5;
  localparam int CB_DIR = 6;
  localparam int CB_CLR = 7;
  localparam logic [7:0] CTRL_KEEP = 8'h63;

  // status bit positions
  localparam int SB_SEL  = 0;
  localparam int SB_PEND = 1;
  localparam int SB_DRY  = 2;

  typedef enum logic [1:0] {X_IDLE, X_MEM, X_ACK} xfer_state_t;

  function automatic logic [2:0] step_bytes(input logic [1:0] code);
    case (code)
      2'd1:    step_bytes = 3'd1;
      2'd2:    step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ppdma_regfile.sv
module ppdma_regfile
  import ppdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_we,
  input  logic [2:0]             reg_addr,
  input  logic [ADDR_W-1:0]      reg_wdata,
  output logic [ADDR_W-1:0]      reg_rdata,
  input  logic                   upd_en,
  input  logic                   upd_sel,
  input  logic [ADDR_W-1:0]      upd_addr,
  input  logic [2:0]             status_i,
  output logic [1:0][ADDR_W-1:0] cur_o,
  output logic [1:0][ADDR_W-1:0] end_o,
  output logic [1:0]             end_wr_o,
  output logic                   clr_o,
  output logic                   en_o,
  output logic                   dir_o,
  output logic [1:0]             size_o
);
  logic [1:0][ADDR_W-1:0] cur_q, end_q;
  logic [7:0]             ctrl_q;

  // per-set write decode: set s sits at OFF_CURA + 2*s and OFF_ENDA + 2*s
  for (genvar s = 0; s < 2; s++) begin : g_set_dec
    assign end_wr_o[s] = reg_we && (reg_addr == OFF_ENDA + 3'(2*s));
  end

  assign clr_o = reg_we && (reg_addr == OFF_CTRL) && reg_wdata[CB_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      end_q  <= '0;
      ctrl_q <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        // a software write wins over the engine's advance
        if (reg_we && (reg_addr == OFF_CURA + 3'(2*s)))
          cur_q[s] <= reg_wdata;
        else if (upd_en && (upd_sel == 1'(s)))
          cur_q[s] <= upd_addr;
        if (end_wr_o[s])
          end_q[s] <= reg_wdata;
      end
      if (reg_we && (reg_addr == OFF_CTRL))
        ctrl_q <= reg_wdata[7:0] & CTRL_KEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        3'd0:     reg_rdata <= cur_q[0];
        3'd1:     reg_rdata <= end_q[0];
        3'd2:     reg_rdata <= cur_q[1];
        3'd3:     reg_rdata <= end_q[1];
        OFF_CTRL: reg_rdata <= {{(ADDR_W-8){1'b0}}, ctrl_q};
        OFF_STAT: reg_rdata <= {{(ADDR_W-3){1'b0}}, status_i};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign cur_o  = cur_q;
  assign end_o  = end_q;
  assign en_o   = ctrl_q[CB_EN];
  assign dir_o  = ctrl_q[CB_DIR];
  assign size_o = ctrl_q[1:0];
endmodule

// File: rtl/ppdma_engine.sv
module ppdma_engine
  import ppdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   en,
  input  logic                   dir,
  input  logic [1:0]             size_code,
  input  logic [1:0]             end_wr,
  input  logic [1:0][ADDR_W-1:0] cur_i,
  input  logic [1:0][ADDR_W-1:0] end_i,
  input  logic                   per_req,
  input  logic [DATA_W-1:0]      per_rdata,
  input  logic [DATA_W-1:0]      mem_rdata,
  input  logic                   mem_ack,
  output logic                   upd_en,
  output logic                   upd_sel,
  output logic [ADDR_W-1:0]      upd_addr,
  output logic [2:0]             status_o,
  output logic                   per_ack,
  output logic [DATA_W-1:0]      per_wdata,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  output logic                   irq
);
  localparam int FIELD_W = ADDR_W - 2;
  localparam int BIT_L   = ADDR_W - 1;
  localparam int BIT_S   = ADDR_W - 2;

  xfer_state_t       xs;
  logic [1:0]        valid_q;
  logic              sel_q;
  logic              stop_q;
  logic [ADDR_W-1:0] act_cur, act_end, nxt_addr;
  logic              running, last_hit, done_evt, dry, pend;

  assign act_cur  = cur_i[sel_q];
  assign act_end  = end_i[sel_q];
  assign running  = en && valid_q[sel_q] && !stop_q;
  assign last_hit = (act_cur[FIELD_W-1:0] == act_end[FIELD_W-1:0]) || act_end[BIT_L];
  assign done_evt = (xs == X_MEM) && mem_ack;
  assign nxt_addr = {act_cur[ADDR_W-1:PAGE_W],
                     act_cur[PAGE_W-1:0] + PAGE_W'(step_bytes(size_code))};

  assign upd_en   = done_evt && !last_hit;
  assign upd_sel  = sel_q;
  assign upd_addr = nxt_addr;

  assign dry  = stop_q || !valid_q[sel_q];
  assign pend = stop_q || !(&valid_q);
  always_comb begin
    status_o          = '0;
    status_o[SB_SEL]  = sel_q;
    status_o[SB_PEND] = pend;
    status_o[SB_DRY]  = dry;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      xs        <= X_IDLE;
      valid_q   <= '0;
      sel_q     <= 1'b0;
      stop_q    <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      per_ack   <= 1'b0;
      per_wdata <= '0;
    end else begin
      per_ack <= 1'b0;
      case (xs)
        X_IDLE: begin
          if (running && per_req) begin
            mem_req   <= 1'b1;
            mem_we    <= dir;
            mem_addr  <= act_cur;
            mem_wdata <= per_rdata;
            xs        <= X_MEM;
          end
        end
        X_MEM: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            per_ack <= 1'b1;
            if (!mem_we) per_wdata <= mem_rdata;
            if (last_hit) begin
              valid_q[sel_q] <= 1'b0;
              sel_q          <= ~sel_q;
              if (act_end[BIT_S]) stop_q <= 1'b1;
            end
            xs <= X_ACK;
          end
        end
        default: xs <= X_IDLE;
      endcase
      // a refill wins over the same-cycle completion of that set
      for (int s = 0; s < 2; s++)
        if (end_wr[s]) valid_q[s] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= pend && en;
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !clr) |=> (mem_req && $stable(mem_addr)));

  p_start_gated_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(en && per_req && !stop_q && valid_q[sel_q]));

  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    per_ack |=> !per_ack);

  p_dry_no_start_r9: assert property (@(posedge clk) disable iff (rst)
    (status_o[SB_DRY] && !mem_req) |=> !mem_req);

  p_stop_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !clr) |=> stop_q);

  p_page_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> (upd_addr[ADDR_W-1:PAGE_W] == mem_addr[ADDR_W-1:PAGE_W]));
endmodule

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan
  import ppdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              per_req,
  output logic              per_ack,
  input  logic [DATA_W-1:0] per_rdata,
  output logic [DATA_W-1:0] per_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              irq
);
  logic [1:0][ADDR_W-1:0] cur_w, end_w;
  logic [1:0]             end_wr_w;
  logic                   clr_w, en_w, dir_w;
  logic [1:0]             size_w;
  logic                   upd_en_w, upd_sel_w;
  logic [ADDR_W-1:0]      upd_addr_w;
  logic [2:0]             status_w;

  ppdma_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .upd_en   (upd_en_w),
    .upd_sel  (upd_sel_w),
    .upd_addr (upd_addr_w),
    .status_i (status_w),
    .cur_o    (cur_w),
    .end_o    (end_w),
    .end_wr_o (end_wr_w),
    .clr_o    (clr_w),
    .en_o     (en_w),
    .dir_o    (dir_w),
    .size_o   (size_w)
  );

  ppdma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_w),
    .en       (en_w),
    .dir      (dir_w),
    .size_code(size_w),
    .end_wr   (end_wr_w),
    .cur_i    (cur_w),
    .end_i    (end_w),
    .per_req  (per_req),
    .per_rdata(per_rdata),
    .mem_rdata(mem_rdata),
    .mem_ack  (mem_ack),
    .upd_en   (upd_en_w),
    .upd_sel  (upd_sel_w),
    .upd_addr (upd_addr_w),
    .status_o (status_w),
    .per_ack  (per_ack),
    .per_wdata(per_wdata),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .irq      (irq)
  );
endmodule

// File: tb/pingpong_dma_chan_bench.sv
module pingpong_dma_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          per_req = 1'b0;
  logic          per_ack;
  logic [DW-1:0] per_rdata = '0;
  logic [DW-1:0] per_wdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_ack;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pingpong_dma_chan #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(6)) u_pingpong_dma_chan (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
    .per_ack(per_ack), .per_rdata(per_rdata), .per_wdata(per_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .irq(irq)
  );

  // memory model: one-cycle acknowledge, read data derived from address
  assign mem_rdata = mem_addr ^ 16'hA5A5;
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else     mem_ack <= mem_req && !mem_ack;
  end

  // transaction logs
  logic [AW-1:0] la [64];
  logic          lw [64];
  logic [DW-1:0] ld [64];
  logic [DW-1:0] lp [64];
  int nlog = 0;
  int npw = 0;
  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      la[nlog[5:0]] <= mem_addr;
      lw[nlog[5:0]] <= mem_we;
      ld[nlog[5:0]] <= mem_wdata;
      nlog <= nlog + 1;
    end
    if (per_ack) begin
      lp[npw[5:0]] <= per_wdata;
      npw <= npw + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [AW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_log(input int target);
    for (int i = 0; i < 300; i++) begin
      if (nlog >= target) break;
      @(negedge clk);
    end
  endtask

  task automatic load_set(input bit b, input logic [AW-1:0] cur, input logic [AW-1:0] fin);
    wr(b ? 3'd2 : 3'd0, cur);
    wr(b ? 3'd3 : 3'd1, fin);
  endtask

  task automatic t_reset();
    logic [AW-1:0] v;
    chk("R3 mem_req after reset", 32'(mem_req), 0);
    chk("R12 irq after reset", 32'(irq), 0);
    rd(3'd5, v); chk("R2 status after reset", 32'(v), 6);
    rd(3'd4, v); chk("R1 ctrl after reset", 32'(v), 0);
  endtask

  task automatic t_regs();
    logic [AW-1:0] v;
    wr(3'd0, 16'h1234); wr(3'd2, 16'h2468);
    rd(3'd0, v); chk("R1 cur-A readback", 32'(v), 32'h1234);
    rd(3'd2, v); chk("R1 cur-B readback", 32'(v), 32'h2468);
    rd(3'd5, v); chk("R13 cur write leaves status", 32'(v), 6);
    wr(3'd1, 16'h1240);
    rd(3'd1, v); chk("R1 end-A readback", 32'(v), 32'h1240);
    rd(3'd5, v); chk("R13 end-A write validates A", 32'(v), 2);
    wr(3'd3, 16'h2470);
    rd(3'd3, v); chk("R1 end-B readback", 32'(v), 32'h2470);
    rd(3'd5, v); chk("R10 both valid clears PEND", 32'(v), 0);
    wr(3'd4, 16'h00FE);
    rd(3'd4, v); chk("R1 ctrl keeps only defined bits", 32'(v), 32'h62);
    wr(3'd4, 16'h0080);
    rd(3'd5, v); chk("R2 status after clear", 32'(v), 6);
  endtask

  task automatic t_pingpong();
    logic [AW-1:0] v;
    int b;
    b = nlog;
    wr(3'd4, 16'h0080);
    load_set(1'b0, 16'h0100, 16'h0104);
    load_set(1'b1, 16'h0200, 16'h0202);
    idle(2);
    chk("R12 irq low with PEND clear", 32'(irq), 0);
    per_rdata = 16'h5A3C; per_req = 1'b1;
    wr(3'd4, 16'h0062);
    wait_log(b + 5);
    idle(8);
    per_req = 1'b0;
    chk("R8 five transfers over A then B", 32'(nlog - b), 5);
    chk("R5 A xfer0 addr", 32'(la[(b+0)%64]), 32'h100);
    chk("R5 A xfer1 addr step 2", 32'(la[(b+1)%64]), 32'h102);
    chk("R7 A last addr", 32'(la[(b+2)%64]), 32'h104);
    chk("R8 B follows A", 32'(la[(b+3)%64]), 32'h200);
    chk("R7 B last addr", 32'(la[(b+4)%64]), 32'h202);
    chk("R4 write direction", 32'(lw[(b+0)%64]), 1);
    chk("R4 write data", 32'(ld[(b+3)%64]), 32'h5A3C);
    rd(3'd5, v); chk("R9 both drained status", 32'(v), 6);
    chk("R12 irq raised when dry and enabled", 32'(irq), 1);
  endtask

  task automatic t_refill();
    logic [AW-1:0] v;
    int b;
    b = nlog;
    wr(3'd4, 16'h0080);
    load_set(1'b0, 16'h0300, 16'h0300);
    per_req = 1'b1;
    wr(3'd4, 16'h0062);
    wait_log(b + 1);
    idle(10);
    per_req = 1'b0;
    chk("R9 no transfer when dry", 32'(nlog - b), 1);
    rd(3'd5, v); chk("R9 DRY and SEL set: refill B", 32'(v), 7);
    load_set(1'b1, 16'h0310, 16'h0312);
    rd(3'd5, v); chk("R9 only SEL set: refill A", 32'(v), 3);
    per_req = 1'b1;
    wait_log(b + 3);
    idle(8);
    per_req = 1'b0;
    chk("R9 refill resumes", 32'(la[(b+1)%64]), 32'h310);
    chk("R9 refill second addr", 32'(la[(b+2)%64]), 32'h312);
    rd(3'd5, v); chk("R8 SEL back to A after B", 32'(v), 6);
  endtask

  task automatic t_stop();
    logic [AW-1:0] v;
    int b;
    b = nlog;
    wr(3'd4, 16'h0080);
    load_set(1'b0, 16'h0400, 16'h4402);
    load_set(1'b1, 16'h0500, 16'h0500);
    per_req = 1'b1;
    wr(3'd4, 16'h0062);
    wait_log(b + 2);
    idle(15);
    chk("R11 stop flag halts before B", 32'(nlog - b), 2);
    rd(3'd5, v); chk("R11 stopped status", 32'(v), 7);
    wr(3'd3, 16'h0500);
    idle(10);
    rd(3'd5, v); chk("R11 refill ignored while stopped", 32'(v), 7);
    chk("R11 no transfer after refill", 32'(nlog - b), 2);
    chk("R11 irq held while stopped", 32'(irq), 1);
    per_req = 1'b0;
    wr(3'd4, 16'h0002);
    idle(2);
    chk("R12 irq masked by disable", 32'(irq), 0);
    wr(3'd4, 16'h0080);
    rd(3'd5, v); chk("R2 clear releases stop", 32'(v), 6);
  endtask

  task automatic t_read_dir();
    int b, p;
    b = nlog; p = npw;
    wr(3'd4, 16'h0080);
    load_set(1'b0, 16'h0600, 16'h0602);
    per_req = 1'b1;
    wr(3'd4, 16'h0021);
    wait_log(b + 3);
    idle(8);
    per_req = 1'b0;
    chk("R5 step 1 addr", 32'(la[(b+1)%64]), 32'h601);
    chk("R5 step 1 last", 32'(la[(b+2)%64]), 32'h602);
    chk("R4 read direction", 32'(lw[(b+1)%64]), 0);
    chk("R4 data to peripheral", 32'(lp[(p+1)%64]), 32'h601 ^ 32'hA5A5);
    chk("R3 one ack per transfer", 32'(npw - p), 3);
  endtask

  task automatic t_page();
    int b;
    b = nlog;
    wr(3'd4, 16'h0080);
    load_set(1'b0, 16'h07F8, 16'h07C0);
    per_req = 1'b1;
    wr(3'd4, 16'h0063);
    wait_log(b + 3);
    idle(8);
    per_req = 1'b0;
    chk("R5 step 4", 32'(la[(b+1)%64]), 32'h7FC);
    chk("R6 wrap inside page", 32'(la[(b+2)%64]), 32'h7C0);
    chk("R6 buffer ends at wrapped addr", 32'(nlog - b), 3);
  endtask

  task automatic t_last_flag();
    logic [AW-1:0] v;
    int b;
    b = nlog;
    wr(3'd4, 16'h0080);
    load_set(1'b0, 16'h0900, 16'h8910);
    per_req = 1'b1;
    idle(10);
    chk("R3 no transfer while disabled", 32'(nlog - b), 0);
    wr(3'd4, 16'h0062);
    wait_log(b + 1);
    idle(10);
    per_req = 1'b0;
    chk("R7 last-transfer flag: one transfer", 32'(nlog - b), 1);
    chk("R7 single transfer addr", 32'(la[b%64]), 32'h900);
    rd(3'd5, v); chk("R7 set invalid after flag", 32'(v), 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_pingpong();
    t_refill();
    t_stop();
    t_read_dir();
    t_page();
    t_last_flag();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule